// File: doc/BRIEF.md
# Bitstream Configuration Loader

The loader sits on a 32-bit register bus and moves a configuration bitstream into one or more target devices. The host sets the expected byte count while the block is off, then switches it on in one of two feed modes. In CPU feed the host writes words into a data window and paces itself by the FIFO fill level. In DMA feed an external engine answers a level request line with bursts of half the FIFO depth. Words leave the FIFO through a byte serializer, most significant byte first, under a valid/ready handshake with the target, and every accepted byte advances the delivered count.

A four-state machine runs the block. OFF is the state after reset and after any control write with the enable bit clear. The START transition (OFF to RUN) is taken on a control write with enable set and reset clear; it clears the counters, the error flags and the timeout timer. RUN streams data. The COMPLETE transition (RUN to DONE) is taken when the delivered count equals the total and the target reports done. The ERROR transition (RUN to FAIL) is taken on any error event; it has priority over COMPLETE. The QUIT transition (RUN, DONE or FAIL to OFF) is taken on a control write with enable clear. The interrupt is high in DONE and FAIL, so only QUIT clears it. A control write with enable and reset both set, kept in OFF, drives the target configuration reset until the next control write.

Register map (word addresses): control 0x40 (bit 0 enable, bit 1 target reset, bit 2 DMA feed), status 0x44, FIFO depth 0x48, fill level 0x4C, total bytes 0x50, delivered bytes 0x54, timeout limit in clock cycles 0x58, data window 0x3000.

Top module: `cfgload_top`

## Requirements
- R1: After reset, control, status (with the target done input low), fill level and delivered count read 0, depth reads DEPTH (8), the timeout limit reads TMO_INIT (100000), and irq, dma_req and tgt_valid are low; the total at 0x50 and the limit at 0x58, written while OFF, read back.
- R2: A control write of 0x3 (enable and reset) leaves the block in OFF and holds tgt_cfg_rst high until the next control write; a control write of 0x2 (reset without enable) keeps tgt_cfg_rst low.
- R3: A control write of 0x1 or 0x5 from OFF enters RUN and sets status bit 0 (busy); a write to the total register while not OFF is ignored.
- R4: Each word is sent as four bytes, most significant first, one per cycle with tgt_valid and tgt_ready high; the delivered count at 0x54 rises by one per such byte, and tgt_valid and tgt_data hold while tgt_ready is low.
- R5: The fill level at 0x4C equals the words written that are not yet fully sent (FIFO content plus the word in the serializer) and reads 0 once all are consumed.
- R6: dma_req is high exactly when the block is in RUN, control bit 2 is set, at least DEPTH/2 FIFO slots are free and fewer bytes have been accepted than the total.
- R7: In RUN, when the delivered count equals the total and tgt_done is high, the block enters DONE: irq rises, status bit 0 clears and status bits 15:1 stay 0; status bit 18 follows tgt_done.
- R8: A data write in RUN with the FIFO full is dropped, sets status bit 1 and enters FAIL with irq high.
- R9: A data write in RUN once the accepted bytes have reached the total is dropped, sets status bit 2 and enters FAIL.
- R10: tgt_err high in RUN sets status bit 3 and enters FAIL.
- R11: Staying in RUN for more than the timeout limit in cycles without completing sets status bit 4 and enters FAIL.
- R12: A control write with bit 0 clear returns to OFF, clears irq and busy and empties the FIFO; the error flags stay readable until the next START clears them.
- R13: Data writes while not in RUN are dropped and leave the fill level at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Level interrupt, high in DONE or FAIL |
| dma_req | output | 1 | Burst request to the external DMA engine |
| tgt_data | output | 8 | Byte to the target |
| tgt_valid | output | 1 | Byte on tgt_data is valid |
| tgt_ready | input | 1 | Target accepts a byte |
| tgt_done | input | 1 | Target reports configuration done |
| tgt_err | input | 1 | Target reports a configuration error |
| tgt_cfg_rst | output | 1 | Configuration reset to the target |

## Verification
The assertions take it that each register write lasts a single cycle and that tgt_ready, tgt_done and tgt_err change only between clock edges, so a byte handshake is decided by the values seen at one edge. The bench drives every input on the falling edge, issues writes as one-cycle strobes with an idle cycle between them, and lets tgt_ready stall the serializer so that holding, draining and FIFO overflow all occur. Completion is only raised by the bench after the expected byte count has been observed at the target side.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;
    typedef enum logic [1:0] {LS_OFF, LS_RUN, LS_DONE, LS_FAIL} ld_state_e;

    localparam logic [15:0] A_CTRL  = 16'h0040;
    localparam logic [15:0] A_STAT  = 16'h0044;
    localparam logic [15:0] A_DEPTH = 16'h0048;
    localparam logic [15:0] A_FILL  = 16'h004C;
    localparam logic [15:0] A_TOTAL = 16'h0050;
    localparam logic [15:0] A_DELIV = 16'h0054;
    localparam logic [15:0] A_TMO   = 16'h0058;
    localparam logic [15:0] A_DATA  = 16'h3000;

    localparam int CB_EN  = 0;
    localparam int CB_RST = 1;
    localparam int CB_DMA = 2;

    localparam int SB_BUSY  = 0;
    localparam int SB_ERRLO = 1;
    localparam int SB_TDONE = 18;

    // error vector: 0 overflow, 1 past total, 2 target error, 3 timeout
    localparam int NERR = 4;
endpackage

// File: rtl/cfgload_fifo.sv
module cfgload_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/cfgload_ser.sv
module cfgload_ser #(
    parameter int W   = 32,
    localparam int NB = W / 8,
    localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         avail,
    input  logic [W-1:0] word_in,
    output logic         take,
    output logic         busy,
    output logic [7:0]   byte_out,
    input  logic         ready
);
    logic [W-1:0]  sh;
    logic [IW-1:0] idx;
    logic          fire, last;

    assign fire     = busy && ready;
    assign last     = fire && (idx == IW'(NB - 1));
    assign take     = avail && (!busy || last) && !flush;
    assign byte_out = sh[8*(NB-1-int'(idx)) +: 8];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            idx  <= '0;
            busy <= 1'b0;
        end else if (flush) begin
            idx  <= '0;
            busy <= 1'b0;
        end else if (take) begin
            sh   <= word_in;
            idx  <= '0;
            busy <= 1'b1;
        end else if (last) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (fire) begin
            idx  <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/cfgload_fsm.sv
module cfgload_fsm
    import cfgload_pkg::*;
#(
    parameter int TMO_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_en,
    input  logic             ctl_rst,
    input  logic             dat_wr,
    input  logic             fifo_full,
    input  logic             past_total,
    input  logic             tgt_err,
    input  logic             bytes_met,
    input  logic             tgt_done,
    input  logic [TMO_W-1:0] tmo_limit,
    output ld_state_e        state,
    output logic             start,
    output logic             run,
    output logic             irq,
    output logic [NERR-1:0]  errs
);
    ld_state_e        nxt;
    logic [TMO_W-1:0] tcnt;
    logic [NERR-1:0]  ev;
    logic             quit;

    assign quit = ctl_wr && !ctl_en;

    always_comb begin
        ev[0] = dat_wr && !past_total && fifo_full;
        ev[1] = dat_wr && past_total;
        ev[2] = tgt_err;
        ev[3] = (tcnt >= tmo_limit);
    end

    always_comb begin
        nxt = state;
        unique case (state)
            LS_OFF:  if (ctl_wr && ctl_en && !ctl_rst) nxt = LS_RUN;
            LS_RUN: begin
                if (quit)                       nxt = LS_OFF;
                else if (|ev)                   nxt = LS_FAIL;
                else if (bytes_met && tgt_done) nxt = LS_DONE;
            end
            LS_DONE, LS_FAIL: if (quit) nxt = LS_OFF;
            default: nxt = LS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LS_OFF;
        else        state <= nxt;
    end

    always_comb begin
        run   = (state == LS_RUN);
        irq   = (state == LS_DONE) || (state == LS_FAIL);
        start = (state == LS_OFF) && (nxt == LS_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            errs <= '0;
            tcnt <= '0;
        end else if (start) begin
            errs <= '0;
            tcnt <= '0;
        end else if (run && !quit) begin
            errs <= errs | ev;
            if (tcnt != '1) tcnt <= tcnt + 1'b1;
        end
    end
endmodule

// File: rtl/cfgload_top.sv
module cfgload_top
    import cfgload_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int ADDR_W   = 16,
    parameter int CNT_W    = 32,
    parameter int TMO_W    = 24,
    parameter int TMO_INIT = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              dma_req,
    output logic [7:0]        tgt_data,
    output logic              tgt_valid,
    input  logic              tgt_ready,
    input  logic              tgt_done,
    input  logic              tgt_err,
    output logic              tgt_cfg_rst
);
    localparam int HALF = DEPTH / 2;
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int FCW  = $clog2(DEPTH + 2);
    localparam int BPW  = 4;

    logic [2:0]       ctrl_q;
    logic [CNT_W-1:0] total_q, deliv_q, acc_q;
    logic [TMO_W-1:0] tmo_q;
    logic             ctl_wr, dat_wr, push_ok, past_total, bytes_met;
    logic             start, run;
    ld_state_e        state;
    logic [NERR-1:0]  errs;
    logic [31:0]      fifo_dout;
    logic [CW-1:0]    fifo_cnt;
    logic             fifo_full, fifo_empty;
    logic             ser_take, ser_busy, fire;
    logic [FCW-1:0]   fill;
    logic [31:0]      status;

    assign ctl_wr     = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
    assign dat_wr     = reg_wr && (reg_addr == ADDR_W'(A_DATA));
    assign past_total = (acc_q >= total_q);
    assign bytes_met  = (deliv_q == total_q);
    assign push_ok    = dat_wr && run && !past_total && !fifo_full;
    assign tgt_valid  = ser_busy && run;
    assign fire       = tgt_valid && tgt_ready;
    assign fill       = FCW'(fifo_cnt) + FCW'(ser_busy);
    assign tgt_cfg_rst = ctrl_q[CB_EN] && ctrl_q[CB_RST];
    assign dma_req    = run && ctrl_q[CB_DMA] && !past_total &&
                        (fifo_cnt <= CW'(DEPTH - HALF));

    cfgload_fsm #(.TMO_W(TMO_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_en(reg_wdata[CB_EN]), .ctl_rst(reg_wdata[CB_RST]),
        .dat_wr(dat_wr), .fifo_full(fifo_full), .past_total(past_total),
        .tgt_err(tgt_err), .bytes_met(bytes_met), .tgt_done(tgt_done),
        .tmo_limit(tmo_q), .state(state), .start(start), .run(run),
        .irq(irq), .errs(errs)
    );

    cfgload_fifo #(.W(32), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(!run),
        .push(push_ok), .din(reg_wdata), .pop(ser_take),
        .dout(fifo_dout), .count(fifo_cnt), .full(fifo_full), .empty(fifo_empty)
    );

    cfgload_ser #(.W(32)) u_ser (
        .clk(clk), .rst_n(rst_n), .flush(!run),
        .avail(!fifo_empty), .word_in(fifo_dout), .take(ser_take),
        .busy(ser_busy), .byte_out(tgt_data), .ready(tgt_ready)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            total_q <= '0;
            tmo_q   <= TMO_W'(TMO_INIT);
            deliv_q <= '0;
            acc_q   <= '0;
        end else begin
            if (ctl_wr) ctrl_q <= reg_wdata[2:0];
            if (reg_wr && state == LS_OFF && reg_addr == ADDR_W'(A_TOTAL))
                total_q <= reg_wdata[CNT_W-1:0];
            if (reg_wr && state == LS_OFF && reg_addr == ADDR_W'(A_TMO))
                tmo_q <= reg_wdata[TMO_W-1:0];
            if (start) begin
                deliv_q <= '0;
                acc_q   <= '0;
            end else begin
                if (fire)    deliv_q <= deliv_q + 1'b1;
                if (push_ok) acc_q   <= acc_q + CNT_W'(BPW);
            end
        end
    end

    always_comb begin
        status = '0;
        status[SB_BUSY] = run;
        status[SB_ERRLO +: NERR] = errs;
        status[SB_TDONE] = tgt_done;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(A_CTRL):  reg_rdata = 32'(ctrl_q);
            ADDR_W'(A_STAT):  reg_rdata = status;
            ADDR_W'(A_DEPTH): reg_rdata = 32'(DEPTH);
            ADDR_W'(A_FILL):  reg_rdata = 32'(fill);
            ADDR_W'(A_TOTAL): reg_rdata = 32'(total_q);
            ADDR_W'(A_DELIV): reg_rdata = 32'(deliv_q);
            ADDR_W'(A_TMO):   reg_rdata = 32'(tmo_q);
            default:          reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfgload_chk.sv
module cfgload_chk
    import cfgload_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 32,
    localparam int HALF  = DEPTH / 2,
    localparam int FCW   = $clog2(DEPTH + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              irq,
    input logic              dma_req,
    input logic              tgt_valid,
    input logic              tgt_ready,
    input logic [7:0]        tgt_data,
    input logic              tgt_cfg_rst,
    input logic              ctl_en,
    input logic              run,
    input logic [FCW-1:0]    fill,
    input logic [CNT_W-1:0]  deliv,
    input logic [CNT_W-1:0]  total,
    input logic [NERR-1:0]   errs
);
    logic off_wr;
    assign off_wr = reg_wr && (reg_addr == ADDR_W'(A_CTRL)) && !reg_wdata[CB_EN];

    // R2: target reset only while the enable bit is held
    a_r2_rst_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_cfg_rst |-> ctl_en);

    // R4: a stalled byte holds while streaming continues
    a_r4_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid && !tgt_ready) |=> (!run || (tgt_valid && $stable(tgt_data))));

    // R4: one count per accepted byte
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid && tgt_ready) |=> (deliv == $past(deliv) + 1'b1));

    // R5: fill never exceeds FIFO plus the serializer word
    a_r5_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FCW'(DEPTH + 1));

    // R6: no request without room for a half-depth burst
    a_r6_req_room: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (fill <= FCW'(HALF + 1)));

    // R7: interrupt rises only on an error or a full delivery
    a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ((errs != '0) || (deliv == total)));

    // R12: disable clears interrupt and busy, then empties storage
    a_r12_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        off_wr |=> (!irq && !run));

    a_r12_off_empties: assert property (@(posedge clk) disable iff (!rst_n)
        off_wr |-> ##2 (fill == '0));
endmodule

bind cfgload_top cfgload_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq(irq), .dma_req(dma_req),
    .tgt_valid(tgt_valid), .tgt_ready(tgt_ready), .tgt_data(tgt_data),
    .tgt_cfg_rst(tgt_cfg_rst), .ctl_en(ctrl_q[0]), .run(run), .fill(fill),
    .deliv(deliv_q), .total(total_q), .errs(errs)
);

// File: tb/tb_cfgload_top.sv
module tb_cfgload_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, dma_req, tgt_valid, tgt_cfg_rst;
    logic [7:0]  tgt_data;
    logic        tgt_ready = 1'b0;
    logic        tgt_done = 1'b0;
    logic        tgt_err = 1'b0;

    int n_total = 0;
    int n_bad   = 0;
    int nb      = 0;
    logic [7:0] got [64];

    always #10 clk = ~clk;

    cfgload_top dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .dma_req(dma_req), .tgt_data(tgt_data), .tgt_valid(tgt_valid),
        .tgt_ready(tgt_ready), .tgt_done(tgt_done), .tgt_err(tgt_err),
        .tgt_cfg_rst(tgt_cfg_rst)
    );

    // behavioural target: records every accepted byte
    always @(posedge clk) begin
        if (tgt_valid && tgt_ready && nb < 64) begin
            got[nb] <= tgt_data;
            nb <= nb + 1;
        end
    end

    // {write, address, write data or expected read data}
    localparam logic [48:0] VEC [10] = '{
        {1'b0, 16'h0040, 32'd0},
        {1'b0, 16'h0044, 32'd0},
        {1'b0, 16'h0048, 32'd8},
        {1'b0, 16'h004C, 32'd0},
        {1'b0, 16'h0054, 32'd0},
        {1'b0, 16'h0058, 32'd100000},
        {1'b1, 16'h0050, 32'd16},
        {1'b0, 16'h0050, 32'd16},
        {1'b1, 16'h0058, 32'd500},
        {1'b0, 16'h0058, 32'd500}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b0;
        #1 v = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_total++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] words [4];
        int base;
        words[0] = 32'h11223344; words[1] = 32'h55667788;
        words[2] = 32'h99AABBCC; words[3] = 32'hDDEEFF00;

        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1: reset outputs
        chk("R1 irq", 32'(irq), 0);
        chk("R1 dma_req", 32'(dma_req), 0);
        chk("R1 tgt_valid", 32'(tgt_valid), 0);
        for (int i = 0; i < 10; i++) begin
            if (VEC[i][48]) wr(VEC[i][47:32], VEC[i][31:0]);
            else begin
                rd(VEC[i][47:32], v);
                chk("R1 register", v, VEC[i][31:0]);
            end
        end

        // R13: data while OFF is dropped
        wr(16'h3000, 32'hCAFEF00D);
        idle(2);
        rd(16'h004C, v); chk("R13 fill", v, 0);

        // R2: configuration reset pulse
        wr(16'h0040, 32'h3);
        idle(1);
        chk("R2 rst high", 32'(tgt_cfg_rst), 1);
        rd(16'h0044, v); chk("R2 not busy", v, 0);
        wr(16'h0040, 32'h0);
        idle(1);
        chk("R2 rst low", 32'(tgt_cfg_rst), 0);
        wr(16'h0040, 32'h2);
        idle(1);
        chk("R2 rst needs enable", 32'(tgt_cfg_rst), 0);
        wr(16'h0040, 32'h0);

        // CPU feed: R3, R4, R5, R7, R12
        base = nb;
        wr(16'h0040, 32'h1);
        rd(16'h0044, v); chk("R3 busy", v, 32'h1);
        wr(16'h0050, 32'd99);
        rd(16'h0050, v); chk("R3 total locked", v, 32'd16);
        for (int i = 0; i < 4; i++) wr(16'h3000, words[i]);
        idle(2);
        rd(16'h004C, v); chk("R5 fill stalled", v, 32'd4);
        tgt_ready = 1'b1;
        idle(30);
        chk("R4 byte count seen", 32'(nb - base), 32'd16);
        for (int i = 0; i < 16; i++)
            chk("R4 byte order", 32'(got[base + i]), 32'((words[i/4] >> (8*(3 - i%4))) & 32'hFF));
        rd(16'h0054, v); chk("R4 delivered", v, 32'd16);
        rd(16'h004C, v); chk("R5 fill drained", v, 0);
        chk("R7 no irq before done", 32'(irq), 0);
        tgt_done = 1'b1;
        idle(2);
        chk("R7 irq", 32'(irq), 1);
        rd(16'h0044, v); chk("R7 status", v, 32'h00040000);
        tgt_done = 1'b0;
        wr(16'h0040, 32'h0);
        idle(2);
        chk("R12 irq cleared", 32'(irq), 0);
        rd(16'h0044, v); chk("R12 status", v, 0);
        tgt_ready = 1'b0;

        // R8: overflow
        wr(16'h0050, 32'd64);
        wr(16'h0040, 32'h1);
        for (int i = 0; i < 10; i++) wr(16'h3000, 32'(i));
        idle(1);
        chk("R8 irq", 32'(irq), 1);
        rd(16'h0044, v); chk("R8 status", v, 32'h2);
        wr(16'h0040, 32'h0);
        idle(2);
        rd(16'h004C, v); chk("R12 fill emptied", v, 0);
        rd(16'h0044, v); chk("R12 flag kept", v, 32'h2);

        // R9: past total
        wr(16'h0050, 32'd8);
        wr(16'h0040, 32'h1);
        for (int i = 0; i < 3; i++) wr(16'h3000, 32'(i));
        idle(1);
        chk("R9 irq", 32'(irq), 1);
        rd(16'h0044, v); chk("R9 status", v, 32'h4);
        wr(16'h0040, 32'h0);

        // R10: target error
        wr(16'h0040, 32'h1);
        rd(16'h0044, v); chk("R12 flags cleared on start", v, 32'h1);
        @(negedge clk); tgt_err = 1'b1;
        @(negedge clk); tgt_err = 1'b0;
        idle(1);
        chk("R10 irq", 32'(irq), 1);
        rd(16'h0044, v); chk("R10 status", v, 32'h8);
        wr(16'h0040, 32'h0);

        // R11: timeout
        wr(16'h0058, 32'd20);
        wr(16'h0040, 32'h1);
        idle(10);
        chk("R11 no early timeout", 32'(irq), 0);
        idle(20);
        chk("R11 irq", 32'(irq), 1);
        rd(16'h0044, v); chk("R11 status", v, 32'h10);
        wr(16'h0040, 32'h0);
        wr(16'h0058, 32'd1000);

        // R6: DMA feed
        wr(16'h0050, 32'd32);
        wr(16'h0040, 32'h5);
        idle(2);
        chk("R6 req empty", 32'(dma_req), 1);
        for (int i = 0; i < 5; i++) wr(16'h3000, 32'(i + 1));
        idle(2);
        chk("R6 req half free", 32'(dma_req), 1);
        wr(16'h3000, 32'h6);
        idle(2);
        chk("R6 req no room", 32'(dma_req), 0);
        tgt_ready = 1'b1;
        wr(16'h3000, 32'h7);
        wr(16'h3000, 32'h8);
        idle(40);
        chk("R6 req total reached", 32'(dma_req), 0);
        rd(16'h0054, v); chk("R4 delivered dma", v, 32'd32);
        tgt_done = 1'b1;
        idle(2);
        chk("R7 irq dma", 32'(irq), 1);
        rd(16'h0044, v); chk("R7 status dma", v, 32'h00040000);
        tgt_done = 1'b0;
        wr(16'h0040, 32'h0);
        tgt_ready = 1'b0;
        idle(2);

        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule